// File: doc/BRIEF.md
# Load-Aware Mesh Channel Selector

This block sits at the egress of one switching module in a full mesh of up to sixteen modules. Each module owns one outbound channel per peer, and every channel reports a queue length that reflects how busy it is. For each cell offered on the request stream, the block picks the outbound channel and returns the choice on a registered result stream. The request carries the destination module and a flag that marks guaranteed-service cells.

Best-effort cells take the direct channel to their destination while that channel's queue is below a programmable threshold. Once it reaches the threshold, they detour through the peer whose queue is shortest. Guaranteed cells always take the direct single-hop channel and draw on a per-channel credit pool that refills at a programmed rate. Best-effort traffic may use a channel only while no guaranteed cell is pending for it.

Both sides are valid/ready streams, and a request transfers on a clock edge where `req_valid` and `req_ready` are both high. There is one output register. `req_ready` is high when that register is empty or is being drained in the same cycle (`sel_ready` high). For a guaranteed request, `req_ready` also needs at least one credit on the destination channel, so `req_ready` may depend on `req_dest` and `req_guar`. While `sel_valid` is high and `sel_ready` is low, the result holds. The result is visible one clock after acceptance.

Top module: `mesh_route_sel`

## Requirements
- R1: A request is accepted on a rising edge with `req_valid` and `req_ready` high. Its result appears on `sel_*` with `sel_valid` high after that edge. `req_ready` is low while a held result is not being drained.
- R2: While `sel_valid` is high and `sel_ready` is low, `sel_chan`, `sel_dest`, `sel_direct` and `sel_guar` do not change.
- R3: A guaranteed request (`req_guar`=1) is routed to channel index `req_dest` with `sel_direct`=1, whatever the loads. It is accepted only when that channel holds at least one credit, and each acceptance uses one credit.
- R4: A best-effort request whose destination is not the local module is routed direct (`sel_chan`=`req_dest`, `sel_direct`=1) when the destination's queue length is strictly below `load_thresh` and `gt_pending[req_dest]` is 0.
- R5: Otherwise it goes to the candidate channel with the smallest queue length, with `sel_direct`=0. A candidate is any index that is not `local_id`, not `req_dest` and has a clear `gt_pending` bit. Among equal lengths, the lowest index wins.
- R6: If R5 finds no candidate, the best-effort request falls back to the direct channel `req_dest` (`sel_direct`=1).
- R7: A request whose `req_dest` equals `local_id` is routed to channel `local_id` with `sel_direct`=1.
- R8: Credits reset to 0. Every `refill_period` cycles (0 or 1 means every cycle), each channel's credit rises by one, up to `credit_cap`.
- R9: When a refill and a guaranteed acceptance hit the same channel in the same cycle, that channel's credit count is unchanged, even at the cap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| local_id | input | 4 | Index of this module (static) |
| load_thresh | input | 8 | Queue length at or above which a channel counts as loaded |
| refill_period | input | 16 | Cycles between credit refills |
| credit_cap | input | 4 | Maximum credits per channel |
| q_len_flat | input | 128 | Queue length per channel, channel i at bits [8i+7:8i] |
| gt_pending | input | 16 | Bit i set: a guaranteed cell is waiting for channel i |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_dest | input | 4 | Destination module index |
| req_guar | input | 1 | 1 = guaranteed-service cell |
| sel_valid | output | 1 | Result valid |
| sel_ready | input | 1 | Downstream takes the result |
| sel_chan | output | 4 | Chosen outbound channel index |
| sel_dest | output | 4 | Destination of the routed request |
| sel_direct | output | 1 | 1 = single-hop delivery to the destination |
| sel_guar | output | 1 | Guaranteed flag of the routed request |

## Verification
Two functions can meet in one cycle: the credit refill tick and the use of a credit by an accepted guaranteed cell on the same channel. With the refill period at 1, the bench fills a channel to its cap and then offers guaranteed cells on consecutive cycles, so every acceptance coincides with a tick. Afterwards it stops the refill and counts how many further guaranteed cells pass before back-pressure. Exactly the cap must pass, which shows the collision neither leaked nor lost a credit. A second overlap is back-pressure on the result stream while a new request waits. The bench checks that the held result is stable and that the waiting request transfers on the edge that drains the result.

// File: rtl/mesh_route_pkg.sv
package mesh_route_pkg;
  typedef enum logic [1:0] {
    RK_LOCAL    = 2'd0,
    RK_DIRECT   = 2'd1,
    RK_DETOUR   = 2'd2,
    RK_FALLBACK = 2'd3
  } route_kind_e;
endpackage

// File: rtl/mrs_credit_bank.sv
module mrs_credit_bank #(
  parameter int N_CH = 16,
  parameter int CW   = 4,
  parameter int PW   = 16,
  localparam int IW  = $clog2(N_CH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PW-1:0]   refill_period,
  input  logic [CW-1:0]   credit_cap,
  input  logic            use_en,
  input  logic [IW-1:0]   use_idx,
  output logic [N_CH-1:0] has_credit
);
  logic [PW-1:0] tick_cnt;
  logic          tick;

  assign tick = (refill_period <= PW'(1)) || (tick_cnt >= refill_period - PW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)    tick_cnt <= '0;
    else if (tick) tick_cnt <= '0;
    else           tick_cnt <= tick_cnt + PW'(1);
  end

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    logic [CW-1:0] cr;
    logic [CW:0]   nxt;
    logic          take;

    assign take = use_en && (use_idx == IW'(g));

    always_comb begin
      nxt = {1'b0, cr} + {{CW{1'b0}}, tick} - {{CW{1'b0}}, take};
      if (nxt > {1'b0, credit_cap}) nxt = {1'b0, credit_cap};
    end

    always_ff @(posedge clk) begin
      if (!rst_n) cr <= '0;
      else        cr <= nxt[CW-1:0];
    end

    assign has_credit[g] = (cr != '0);

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> cr != '0);  // R3
    AST_NET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (take && tick && cr <= credit_cap) |=> cr == $past(cr));  // R9
  end
endmodule

// File: rtl/mrs_min_finder.sv
module mrs_min_finder #(
  parameter int N_CH = 16,
  parameter int QW   = 8,
  localparam int IW  = $clog2(N_CH)
) (
  input  logic [N_CH*QW-1:0] q_flat,
  input  logic [N_CH-1:0]    cand,
  output logic               found,
  output logic [IW-1:0]      best_idx
);
  logic [QW-1:0] best_len;

  always_comb begin
    found    = 1'b0;
    best_idx = '0;
    best_len = '1;
    for (int i = 0; i < N_CH; i++) begin
      if (cand[i] && (!found || q_flat[i*QW +: QW] < best_len)) begin
        found    = 1'b1;
        best_idx = IW'(i);
        best_len = q_flat[i*QW +: QW];
      end
    end
  end
endmodule

// File: rtl/mrs_decide.sv
module mrs_decide
  import mesh_route_pkg::*;
#(
  parameter int N_CH = 16,
  parameter int QW   = 8,
  localparam int IW  = $clog2(N_CH)
) (
  input  logic [IW-1:0]      dest,
  input  logic               guar,
  input  logic [IW-1:0]      local_id,
  input  logic [QW-1:0]      thresh,
  input  logic [N_CH*QW-1:0] q_flat,
  input  logic [N_CH-1:0]    gt_pend,
  output logic [IW-1:0]      chan,
  output route_kind_e        kind
);
  logic [N_CH-1:0] cand;
  logic            found;
  logic [IW-1:0]   best;
  logic            dest_free;

  for (genvar g = 0; g < N_CH; g++) begin : g_cand
    assign cand[g] = (IW'(g) != local_id) && (IW'(g) != dest) && !gt_pend[g];
  end

  mrs_min_finder #(.N_CH(N_CH), .QW(QW)) u_min (
    .q_flat  (q_flat),
    .cand    (cand),
    .found   (found),
    .best_idx(best)
  );

  assign dest_free = (q_flat[dest*QW +: QW] < thresh) && !gt_pend[dest];

  always_comb begin
    if (dest == local_id) begin
      chan = local_id;
      kind = RK_LOCAL;
    end else if (guar || dest_free) begin
      chan = dest;
      kind = RK_DIRECT;
    end else if (found) begin
      chan = best;
      kind = RK_DETOUR;
    end else begin
      chan = dest;
      kind = RK_FALLBACK;
    end
  end
endmodule

// File: rtl/mesh_route_sel.sv
module mesh_route_sel
  import mesh_route_pkg::*;
#(
  parameter int N_CH = 16,
  parameter int QW   = 8,
  parameter int CW   = 4,
  parameter int PW   = 16,
  localparam int IW  = $clog2(N_CH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [IW-1:0]      local_id,
  input  logic [QW-1:0]      load_thresh,
  input  logic [PW-1:0]      refill_period,
  input  logic [CW-1:0]      credit_cap,
  input  logic [N_CH*QW-1:0] q_len_flat,
  input  logic [N_CH-1:0]    gt_pending,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [IW-1:0]      req_dest,
  input  logic               req_guar,
  output logic               sel_valid,
  input  logic               sel_ready,
  output logic [IW-1:0]      sel_chan,
  output logic [IW-1:0]      sel_dest,
  output logic               sel_direct,
  output logic               sel_guar
);
  logic [N_CH-1:0] has_credit;
  logic            slot_free;
  logic            accept;
  logic [IW-1:0]   dec_chan;
  route_kind_e     dec_kind;

  assign slot_free = !sel_valid || sel_ready;
  assign req_ready = slot_free && (!req_guar || has_credit[req_dest]);
  assign accept    = req_valid && req_ready;

  mrs_credit_bank #(.N_CH(N_CH), .CW(CW), .PW(PW)) u_credit (
    .clk          (clk),
    .rst_n        (rst_n),
    .refill_period(refill_period),
    .credit_cap   (credit_cap),
    .use_en       (accept && req_guar),
    .use_idx      (req_dest),
    .has_credit   (has_credit)
  );

  mrs_decide #(.N_CH(N_CH), .QW(QW)) u_decide (
    .dest    (req_dest),
    .guar    (req_guar),
    .local_id(local_id),
    .thresh  (load_thresh),
    .q_flat  (q_len_flat),
    .gt_pend (gt_pending),
    .chan    (dec_chan),
    .kind    (dec_kind)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_valid  <= 1'b0;
      sel_chan   <= '0;
      sel_dest   <= '0;
      sel_direct <= 1'b0;
      sel_guar   <= 1'b0;
    end else if (slot_free) begin
      sel_valid <= accept;
      if (accept) begin
        sel_chan   <= dec_chan;
        sel_dest   <= req_dest;
        sel_direct <= (dec_kind != RK_DETOUR);
        sel_guar   <= req_guar;
      end
    end
  end

  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid && !sel_ready) |=> sel_valid && $stable(sel_chan) && $stable(sel_dest)
      && $stable(sel_guar) && $stable(sel_direct));  // R2
  AST_NO_TAKE_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid && !sel_ready) |-> !req_ready);  // R1
  AST_GUAR_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid && sel_guar) |-> (sel_chan == sel_dest) && sel_direct);  // R3
  AST_DETOUR_AVOIDS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_guar && dec_chan != req_dest) |->
      (dec_chan != local_id) && !gt_pending[dec_chan]);  // R5
  AST_LOCAL_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_dest == local_id) |-> dec_chan == local_id);  // R7
endmodule

// File: tb/tb_mesh_route_sel.sv
module tb_mesh_route_sel;
  localparam int N = 16;
  localparam int QW = 8;

  logic clk = 0;
  logic rst_n = 0;
  logic [3:0]  local_id = 4'd2;
  logic [7:0]  load_thresh = 8'd100;
  logic [15:0] refill_period = 16'hFFFF;
  logic [3:0]  credit_cap = 4'd3;
  logic [N*QW-1:0] q_len_flat;
  logic [N-1:0] gt_pending = '0;
  logic req_valid = 0, req_guar = 0, sel_ready = 1;
  logic [3:0] req_dest = 0;
  logic req_ready, sel_valid, sel_direct, sel_guar;
  logic [3:0] sel_chan, sel_dest;
  logic [7:0] ql [N];

  int total = 0, bad = 0;
  logic done = 0;

  always #10 clk = ~clk;

  always_comb
    for (int i = 0; i < N; i++) q_len_flat[i*QW +: QW] = ql[i];

  mesh_route_sel dut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int model(input int d, input bit g);
    int best;
    best = -1;
    if (d == int'(local_id)) return int'(local_id);
    if (g) return d;
    if (ql[d] < load_thresh && !gt_pending[d]) return d;
    for (int i = 0; i < N; i++)
      if (i != int'(local_id) && i != d && !gt_pending[i])
        if (best < 0 || ql[i] < ql[best]) best = i;
    return (best < 0) ? d : best;
  endfunction

  task automatic route(input string tag, input int d, input bit g, input int exp);
    @(negedge clk);
    req_dest = 4'(d); req_guar = g; req_valid = 1;
    #1 chk({tag, " ready"}, int'(req_ready), 1);
    @(negedge clk);
    req_valid = 0;
    #1 chk({tag, " valid"}, int'(sel_valid), 1);
    chk({tag, " chan"}, int'(sel_chan), exp);
    chk({tag, " direct"}, int'(sel_direct), int'(exp == d || d == int'(local_id)));
  endtask

  task automatic t_reset;
    @(negedge clk); #1;
    chk("R1 reset sel_valid", int'(sel_valid), 0);
    req_dest = 4'd5; req_guar = 1;
    #1 chk("R8 no credit after reset", int'(req_ready), 0);
    req_guar = 0;
  endtask

  task automatic t_direct_and_local;
    for (int i = 0; i < N; i++) ql[i] = 8'd50;
    route("R4 direct unloaded", 7, 0, 7);
    ql[7] = 8'd99;
    route("R4 just below threshold", 7, 0, 7);
    route("R7 local dest", 2, 0, 2);
    gt_pending[7] = 1;
    ql[7] = 8'd10;
    route("R4 pending forces detour", 7, 0, 0);
    gt_pending[7] = 0;
  endtask

  task automatic t_detour;
    for (int i = 0; i < N; i++) ql[i] = 8'd50;
    ql[7] = 8'd100;
    route("R5 loaded at threshold tie lowest", 7, 0, 0);
    ql[0] = 8'd60; ql[1] = 8'd60; ql[3] = 8'd10; ql[9] = 8'd10; ql[2] = 8'd0;
    route("R5 min skips local", 7, 0, 3);
    gt_pending[3] = 1;
    route("R5 pending candidate skipped", 7, 0, 9);
    gt_pending = ~(16'h0001 << 7);
    gt_pending[2] = 0;
    route("R6 no candidate fallback", 7, 0, 7);
    gt_pending = '0;
  endtask

  task automatic t_credit_collision;
    refill_period = 16'd1;
    repeat (8) @(negedge clk);
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      req_dest = 4'd5; req_guar = 1; req_valid = 1;
      #1 chk("R9 refill covers use", int'(req_ready), 1);
    end
    @(negedge clk);
    refill_period = 16'hFFFF;
    #1 chk("R3 guar routed direct", int'(sel_chan), 5);
    chk("R3 guar flag", int'(sel_guar), 1);
    for (int k = 0; k < 3; k++) begin
      if (k > 0) @(negedge clk);
      #1 chk("R9 cap intact after collisions", int'(req_ready), 1);
    end
    @(negedge clk);
    #1 chk("R3 credit exhausted stalls", int'(req_ready), 0);
    req_valid = 0;
    refill_period = 16'd4;
    repeat (10) @(negedge clk);
    #1 chk("R8 refill restores credit", int'(req_ready), 1);
    refill_period = 16'hFFFF;
    req_guar = 0;
    for (int i = 0; i < N; i++) ql[i] = 8'd200;
    route("R3 guar ignores load", 5, 1, 5);
  endtask

  task automatic t_backpressure;
    for (int i = 0; i < N; i++) ql[i] = 8'd20;
    @(negedge clk);
    sel_ready = 0;
    req_dest = 4'd4; req_guar = 0; req_valid = 1;
    @(negedge clk);
    req_dest = 4'd9;
    #1 chk("R1 blocked while full", int'(req_ready), 0);
    repeat (3) @(negedge clk);
    #1 chk("R2 held chan", int'(sel_chan), 4);
    chk("R2 held valid", int'(sel_valid), 1);
    sel_ready = 1;
    #1 chk("R1 ready on drain", int'(req_ready), 1);
    @(negedge clk);
    req_valid = 0;
    #1 chk("R1 next result", int'(sel_chan), 9);
  endtask

  task automatic t_random;
    logic [15:0] lf = 16'hACE1;
    for (int n = 0; n < 40; n++) begin
      for (int i = 0; i < N; i++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        ql[i] = lf[7:0];
        gt_pending[i] = (lf[9:8] == 2'b00);
      end
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      route("R5 random vs model", int'(lf[3:0]), 0, model(int'(lf[3:0]), 0));
    end
    gt_pending = '0;
  endtask

  initial begin
    for (int i = 0; i < N; i++) ql[i] = 8'd0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_direct_and_local();
    t_detour();
    t_credit_collision();
    t_backpressure();
    t_random();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule